// File: doc/BRIEF.md
# Multi-Channel Interrupt Capture and Priority Selector

This block gathers up to 64 asynchronous interrupt lines, brings each one into the clock domain, and records the requests in pending flags. Each flag is gated by its enable bit. A binary tree of comparators picks the winning pending and enabled line, and the block presents that line's number to the processor. The processor answers with a one-cycle acknowledge that names the line it has taken. If software has chosen so, that acknowledge also retires the pending flag.

Up to 32 of the lowest-numbered lines have a trigger condition set by software: active-low level, rising edge, falling edge or any change. All higher lines fire on a high level. Software reads the flags, the enables, the trigger settings and one control bit through a small word-wide port, and writes them through the same port. Translating the line number into a handler vector or address is left to a separate block.

Top module: `irq_channel_ctrl`

## Requirements
- R1: The line count `N_CH` (2..64) and the count of lines with a selectable trigger `N_SENSE` (at most 32 and at most `N_CH`) are parameters. Lines `N_SENSE` and above always trigger on a high level.
- R2: Selectable lines use a 2-bit trigger code: 00 = input low, 01 = rising edge, 10 = falling edge, 11 = either edge. Line i's code sits at bits [2(i%16)+1 : 2(i%16)] of word 4 for lines 0..15, and of word 5 for lines 16..31. All codes reset to 00.
- R3: Each input passes through two flip-flops. An input change made before clock edge k is reflected in the pending flag after edge k+2.
- R4: Pending bit i belongs to line i. Lines 0..31 are in word 0 and lines 32..63 are in word 1. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Flags reset to 0.
- R5: A trigger event that lands in the same cycle as a clear of that flag, whether the clear comes from software or from an acknowledge, leaves the flag set.
- R6: Enable bit i (word 2 for lines 0..31, word 3 for lines 32..63) gates only the request. A disabled flag stays readable. Enables reset to 0.
- R7: `irq_id` is one plus the number of the highest-numbered line that is both pending and enabled, and `irq_req` is high. With no such line, `irq_id` is 0 and `irq_req` is low. Both follow the flag and enable registers in the same cycle.
- R8: Bit 0 of word 6 (auto-clear, reset 0) set means that a cycle with `ack` high and a non-zero `ack_id` clears the flag of line `ack_id`-1 at that edge. With the bit at 0, or with `ack_id` 0, the acknowledge changes nothing.
- R9: A fixed high-level line whose input stays high sets its flag again in every cycle, so a software clear does not stick while the level lasts.
- R10: Word 7 reads as 0. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_CH | Asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_req | output | 1 | A pending, enabled line exists |
| irq_id | output | $clog2(N_CH+1) | Winning line number plus one, 0 if none |
| ack | input | 1 | One-cycle acknowledge from the processor |
| ack_id | input | $clog2(N_CH+1) | Line number plus one being serviced |

## Verification
A corrupted pending flag or a wrong trigger decode shows at `irq_id` in the same cycle as the flag register, because selection is purely combinational after the flags. A bench that compares `irq_id` on every clock therefore sees such a fault as soon as the affected line is enabled and is the highest pending one. Faults that stay hidden behind higher lines or disabled bits are exposed through register reads of the flag words. Synchroniser depth errors show up as a one-cycle shift against the cycle-exact model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_ANY  = 2'b11
    } sense_e;

    localparam logic [2:0] ADR_FLAG_LO = 3'd0;
    localparam logic [2:0] ADR_FLAG_HI = 3'd1;
    localparam logic [2:0] ADR_EN_LO   = 3'd2;
    localparam logic [2:0] ADR_EN_HI   = 3'd3;
    localparam logic [2:0] ADR_MODE_A  = 3'd4;
    localparam logic [2:0] ADR_MODE_B  = 3'd5;
    localparam logic [2:0] ADR_CTRL    = 3'd6;

    localparam int WORD_W = 32;
    localparam int MAX_CH = 64;

    typedef struct packed {
        logic              wr;
        logic [2:0]        addr;
        logic [WORD_W-1:0] data;
    } reg_cmd_t;

    // decide whether a synchronised sample pair is a trigger for the code
    function automatic logic sense_hit(sense_e code, logic cur, logic prev);
        case (code)
            SENSE_LOW:  return !cur;
            SENSE_RISE: return cur && !prev;
            SENSE_FALL: return !cur && prev;
            default:    return cur ^ prev;
        endcase
    endfunction

endpackage

// File: rtl/irqc_sense.sv
module irqc_sense
    import irqc_pkg::*;
#(
    parameter int N_CH    = 64,
    parameter int N_SENSE = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_CH-1:0]          raw,
    input  logic [N_SENSE-1:0][1:0]  mode,
    output logic [N_CH-1:0]          evt
);

    logic [N_CH-1:0]    sy1;
    logic [N_CH-1:0]    sy2;
    logic [N_SENSE-1:0] prv;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy1 <= '0;
            sy2 <= '0;
            prv <= '0;
        end else begin
            sy1 <= raw;
            sy2 <= sy1;
            prv <= sy2[N_SENSE-1:0];
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        if (i < N_SENSE) begin : g_cfg
            assign evt[i] = sense_hit(sense_e'(mode[i]), sy2[i], prv[i]);
        end else begin : g_fix
            assign evt[i] = sy2[i];
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_CH    = 64,
    parameter int N_SENSE = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  reg_cmd_t                 cmd,
    input  logic [N_CH-1:0]          flag,
    output logic [N_CH-1:0]          en_q,
    output logic [N_SENSE-1:0][1:0]  mode_q,
    output logic                     auto_clr,
    output logic [N_CH-1:0]          clr_sw,
    output logic [WORD_W-1:0]        rdata
);

    logic [MAX_CH-1:0]   flag_w;
    logic [MAX_CH-1:0]   en_w;
    logic [2*WORD_W-1:0] mode_w;

    assign flag_w = MAX_CH'(flag);
    assign en_w   = MAX_CH'(en_q);

    for (genvar i = 0; i < N_SENSE; i++) begin : g_mode_rd
        assign mode_w[2*i +: 2] = mode_q[i];
    end
    if (N_SENSE < WORD_W) begin : g_mode_pad
        assign mode_w[2*WORD_W-1:2*N_SENSE] = '0;
    end

    // write-one-to-clear decode, one bit per line
    for (genvar i = 0; i < N_CH; i++) begin : g_clr
        localparam logic [2:0] WADR = (i < WORD_W) ? ADR_FLAG_LO : ADR_FLAG_HI;
        assign clr_sw[i] = cmd.wr && (cmd.addr == WADR) && cmd.data[i % WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            auto_clr <= 1'b0;
        end else if (cmd.wr) begin
            case (cmd.addr)
                ADR_EN_LO: en_q     <= N_CH'({en_w[MAX_CH-1:WORD_W], cmd.data});
                ADR_EN_HI: en_q     <= N_CH'({cmd.data, en_w[WORD_W-1:0]});
                ADR_CTRL:  auto_clr <= cmd.data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            for (int i = 0; i < N_SENSE; i++) begin
                if (cmd.wr && cmd.addr == ((i < 16) ? ADR_MODE_A : ADR_MODE_B))
                    mode_q[i] <= cmd.data[2*(i % 16) +: 2];
            end
        end
    end

    always_comb begin
        case (cmd.addr)
            ADR_FLAG_LO: rdata = flag_w[WORD_W-1:0];
            ADR_FLAG_HI: rdata = flag_w[MAX_CH-1:WORD_W];
            ADR_EN_LO:   rdata = en_w[WORD_W-1:0];
            ADR_EN_HI:   rdata = en_w[MAX_CH-1:WORD_W];
            ADR_MODE_A:  rdata = mode_w[WORD_W-1:0];
            ADR_MODE_B:  rdata = mode_w[2*WORD_W-1:WORD_W];
            ADR_CTRL:    rdata = {{(WORD_W-1){1'b0}}, auto_clr};
            default:     rdata = '0;
        endcase
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && cmd.addr == ADR_CTRL) |=> $stable(auto_clr)); // R8
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && (cmd.addr == ADR_EN_LO || cmd.addr == ADR_EN_HI)) |=> $stable(en_q)); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && (cmd.addr == ADR_MODE_A || cmd.addr == ADR_MODE_B)) |=> $stable(mode_q)); // R2

endmodule

// File: rtl/irqc_tree.sv
module irqc_tree #(
    parameter int N    = 64,
    parameter int ID_W = $clog2(N+1)
) (
    input  logic [N-1:0]    req,
    output logic            hit,
    output logic [ID_W-1:0] id
);

    localparam int LVL   = (N > 1) ? $clog2(N) : 1;
    localparam int W     = 1 << LVL;
    localparam int NODES = 2*W - 1;

    logic [NODES-1:0]          nv;
    logic [NODES-1:0][LVL-1:0] ni;

    for (genvar i = 0; i < W; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign nv[W-1+i] = req[i];
        end else begin : g_pad
            assign nv[W-1+i] = 1'b0;
        end
        assign ni[W-1+i] = LVL'(i);
    end

    // node k has children 2k+1 (lower lines) and 2k+2 (higher lines)
    for (genvar k = 0; k < W-1; k++) begin : g_node
        assign nv[k] = nv[2*k+1] | nv[2*k+2];
        assign ni[k] = nv[2*k+2] ? ni[2*k+2] : ni[2*k+1];
    end

    assign hit = nv[0];
    assign id  = hit ? (ID_W'(ni[0]) + ID_W'(1)) : '0;

endmodule

// File: rtl/irq_channel_ctrl.sv
module irq_channel_ctrl
    import irqc_pkg::*;
#(
    parameter  int N_CH    = 64,
    parameter  int N_SENSE = 32,
    localparam int ID_W    = $clog2(N_CH+1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   irq_in,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    input  logic              ack,
    input  logic [ID_W-1:0]   ack_id
);

    logic [N_CH-1:0]          evt;
    logic [N_CH-1:0]          flag_q;
    logic [N_CH-1:0]          en_q;
    logic [N_CH-1:0]          clr_sw;
    logic [N_CH-1:0]          clr_ack;
    logic [N_CH-1:0]          pend;
    logic [N_SENSE-1:0][1:0]  mode_q;
    logic                     auto_clr;
    reg_cmd_t                 cmd;

    assign cmd = '{wr: reg_wr, addr: reg_addr, data: reg_wdata};

    irqc_sense #(.N_CH(N_CH), .N_SENSE(N_SENSE)) u_sense (
        .clk (clk), .rst (rst), .raw (irq_in), .mode (mode_q), .evt (evt)
    );

    irqc_regs #(.N_CH(N_CH), .N_SENSE(N_SENSE)) u_regs (
        .clk (clk), .rst (rst), .cmd (cmd), .flag (flag_q),
        .en_q (en_q), .mode_q (mode_q), .auto_clr (auto_clr),
        .clr_sw (clr_sw), .rdata (reg_rdata)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ack
        assign clr_ack[i] = ack && auto_clr && (ack_id == ID_W'(i + 1));
    end

    // a fresh event overrides any clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~(clr_sw | clr_ack)) | evt;
    end

    assign pend = flag_q & en_q;

    irqc_tree #(.N(N_CH), .ID_W(ID_W)) u_tree (
        .req (pend), .hit (irq_req), .id (irq_id)
    );

    AST_REQ_ANY: assert property (@(posedge clk) disable iff (rst)
        irq_req == (|pend)); // R7
    AST_WINNER_TOP: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (N_CH'(pend >> (irq_id - ID_W'(1))) == N_CH'(1))); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flag_q & $past(evt)) == $past(evt))); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|clr_ack) |=> ((flag_q & $past(clr_ack & ~evt)) == '0)); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flag_q & ~$past(flag_q) & ~$past(evt)) == '0)); // R4

endmodule

// File: tb/sim_irq_channel_ctrl.sv
module sim_irq_channel_ctrl;

    localparam int CLK_P = 10;
    localparam int NCH   = 64;
    localparam int IDW   = 7;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] irq_in = '0;
    logic           reg_wr = 1'b0;
    logic [2:0]     reg_addr = 3'd0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           irq_req;
    logic [IDW-1:0] irq_id;
    logic           ack = 1'b0;
    logic [IDW-1:0] ack_id = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_channel_ctrl u0 (
        .clk (clk), .rst (rst), .irq_in (irq_in), .reg_wr (reg_wr),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq_req (irq_req), .irq_id (irq_id), .ack (ack), .ack_id (ack_id)
    );

    // ---------------- behavioural reference ----------------
    logic [63:0] m_s1, m_s2, m_s3, m_flag, m_en, m_mode, m_ev, m_clr;
    logic        m_auto;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_flag = '0;
            m_en = '0; m_mode = '0; m_auto = 1'b0;
        end else begin
            for (int i = 0; i < 64; i++) begin
                if (i < 32) begin
                    case (m_mode[2*i +: 2])
                        2'b00:   m_ev[i] = !m_s2[i];
                        2'b01:   m_ev[i] = m_s2[i] && !m_s3[i];
                        2'b10:   m_ev[i] = !m_s2[i] && m_s3[i];
                        default: m_ev[i] = m_s2[i] != m_s3[i];
                    endcase
                end else begin
                    m_ev[i] = m_s2[i];
                end
            end
            m_clr = '0;
            if (reg_wr && reg_addr == 3'd0) m_clr[31:0]  = reg_wdata;
            if (reg_wr && reg_addr == 3'd1) m_clr[63:32] = reg_wdata;
            if (ack && m_auto && ack_id != 0) m_clr[ack_id - 1] = 1'b1;
            m_flag = (m_flag & ~m_clr) | m_ev;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_in;
            if (reg_wr) begin
                case (reg_addr)
                    3'd2: m_en[31:0]    = reg_wdata;
                    3'd3: m_en[63:32]   = reg_wdata;
                    3'd4: m_mode[31:0]  = reg_wdata;
                    3'd5: m_mode[63:32] = reg_wdata;
                    3'd6: m_auto        = reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [IDW-1:0] m_winner();
        logic [63:0] p;
        p = m_flag & m_en;
        for (int i = 63; i >= 0; i--) if (p[i]) return IDW'(i + 1);
        return '0;
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_flag[31:0];
            3'd1: return m_flag[63:32];
            3'd2: return m_en[31:0];
            3'd3: return m_en[63:32];
            3'd4: return m_mode[31:0];
            3'd5: return m_mode[63:32];
            3'd6: return {31'b0, m_auto};
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison of the request outputs against the model (R7)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 irq_id per cycle", 32'(irq_id), 32'(m_winner()));
            chk("R7 irq_req per cycle", 32'(irq_req), 32'(m_winner() != 0));
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, reg_rdata, m_read(a));
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_ack(logic [IDW-1:0] id);
        ack = 1'b1; ack_id = id;
        @(negedge clk);
        ack = 1'b0; ack_id = '0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // reset state
        rd("R6 enable lo reset", 3'd2, 32'h0);
        rd("R2 mode reset", 3'd4, 32'h0);
        rd("R8 ctrl reset", 3'd6, 32'h0);
        rd("R10 word7", 3'd7, 32'h0);
        chk("R7 no request after reset", 32'(irq_req), 32'h0);

        // low-level lines stop firing once driven high, then clear all
        irq_in = 64'h0000_0000_FFFF_FFFF;
        cyc(4);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        rd("R4 flags cleared", 3'd0, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        rd("R6 enable hi", 3'd3, 32'hFFFF_FFFF);

        // R3 latency on a rising-edge line 3
        wr(3'd4, 32'h0000_0040);
        irq_in[3] = 1'b0;
        cyc(4);
        rd("R3 idle before edge", 3'd0, 32'h0);
        irq_in[3] = 1'b1;
        @(negedge clk); rd("R3 after one edge", 3'd0, 32'h0);
        @(negedge clk); rd("R3 after two edges", 3'd0, 32'h0);
        @(negedge clk); rd("R3 after three edges", 3'd0, 32'h8);
        chk("R7 winner is line 3", 32'(irq_id), 32'd4);

        // R4 write zero keeps, write one clears
        wr(3'd0, 32'h0);
        rd("R4 zero write no effect", 3'd0, 32'h8);
        wr(3'd0, 32'h8);
        rd("R4 one write clears", 3'd0, 32'h0);

        // R5 clear coinciding with an event, line 3 in any-edge mode
        wr(3'd4, 32'h0000_00C0);
        irq_in[3] = 1'b0;
        cyc(3);
        rd("R2 any-edge falling sets", 3'd0, 32'h8);
        irq_in[3] = 1'b1;
        cyc(2);
        wr(3'd0, 32'h8);
        rd("R5 event beats clear", 3'd0, 32'h8);
        wr(3'd0, 32'h8);
        rd("R4 plain clear", 3'd0, 32'h0);

        // R8 auto-clear on acknowledge
        irq_in[3] = 1'b0;
        cyc(3);
        wr(3'd6, 32'h1);
        chk("R8 pre-ack winner", 32'(irq_id), 32'd4);
        do_ack(IDW'(4));
        rd("R8 ack clears flag", 3'd0, 32'h0);
        chk("R8 no request after ack", 32'(irq_req), 32'h0);
        irq_in[3] = 1'b1;
        cyc(3);
        wr(3'd6, 32'h0);
        do_ack(IDW'(4));
        rd("R8 ack without auto-clear", 3'd0, 32'h8);
        wr(3'd6, 32'h1);
        do_ack(IDW'(0));
        rd("R8 ack id zero ignored", 3'd0, 32'h8);
        wr(3'd0, 32'h8);

        // R9 fixed level-high line 50
        irq_in[50] = 1'b1;
        cyc(3);
        chk("R9 line 50 wins", 32'(irq_id), 32'd51);
        rd("R9 flag hi", 3'd1, 32'h0004_0000);
        wr(3'd1, 32'h0004_0000);
        rd("R9 clear does not stick", 3'd1, 32'h0004_0000);

        // R6 disabled flag stays readable, no request
        wr(3'd3, 32'h0);
        chk("R6 disabled no request", 32'(irq_id), 32'd0);
        rd("R6 flag still readable", 3'd1, 32'h0004_0000);
        irq_in[50] = 1'b0;
        cyc(3);
        wr(3'd1, 32'h0004_0000);
        rd("R9 clear after level drops", 3'd1, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);

        // R2 falling edge on line 5 and upper mode word
        wr(3'd4, 32'h0000_0800);
        irq_in[5] = 1'b0;
        cyc(3);
        chk("R2 falling line 5", 32'(irq_id), 32'd6);
        rd("R2 mode word A", 3'd4, 32'h0000_0800);
        wr(3'd5, 32'h0000_0001);
        rd("R2 mode word B", 3'd5, 32'h0000_0001);
        rd("R1 line 32 is level-high idle", 3'd1, 32'h0);
        rd("R10 word7 again", 3'd7, 32'h0);

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 16);
            if (($urandom % 3) == 0) irq_in[$urandom % 64] ^= 1'b1;
            if (r == 0) begin
                wr(3'($urandom % 7), $urandom);
            end else if (r == 1 && irq_req) begin
                do_ack(irq_id);
            end else if (r == 2) begin
                reg_addr = 3'($urandom % 8);
                #1;
                chk("R4 readback vs model", reg_rdata, m_read(reg_addr));
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule